// File: doc/BRIEF.md
# Retention Freeze Sequencer

This block sequences a chip region into and out of a retention freeze. An active-low freeze pin arrives asynchronously; it is brought into the clock domain and turned into a request to user logic. User logic answers with a grant when it has reached a safe point. Only then does the sequencer drop the clock enable of the protected core, latch the core's inputs, and park its outputs at a configured idle state. The external clock keeps running and the core's registers and memories simply stop updating, so their contents are retained.

When the pin is released, the sequencer runs a short fixed wake-up interval and then restores the clock enable, live inputs and normal output drive together. If the pin is released before user logic grants, the request is withdrawn and nothing freezes. With freeze support switched off by parameter the pin is only a synchronized ordinary input.

Top module: `frz_seq`

## Requirements
- R1: The pin passes through two synchronizing flops; its synchronized level appears on `pin_level` two rising edges after it changes, and `frz_req` rises on the third rising edge after the pin is driven low.
- R2: The region freezes only on a grant: with `frz_req` high and `safe_grant` high at a rising edge, `frozen` is high after that edge; with the pin held low and no grant, `frozen` stays low and `core_ce` stays high indefinitely.
- R3: While `frozen` is high, `core_ce` is low; it changes only at rising edges.
- R4: While `frozen` is low, `in_core` equals `in_raw`; while `frozen` is high, `in_core` holds the value `in_raw` had at the entry edge, whatever `in_raw` does.
- R5: While `frozen` is high, `out_oe` is all zero, `out_pad` is all zero, `out_pull_en` equals parameter `IDLE_PULL_EN` and `out_pull_up` equals `IDLE_PULL_UP`; while `frozen` is low, `out_pad`/`out_oe` follow `out_core`/`out_oe_core` and `out_pull_en`/`out_pull_up` are zero.
- R6: After the pin is driven high, `frozen` drops and `core_ce` returns exactly 3 + `WAKE_CYCLES` rising edges later (7 at defaults), with retained held inputs released to live values at that same edge.
- R7: If the pin is released while `frz_req` is high and before a grant, `frz_req` drops on the third rising edge after release, no freeze happens, and a grant arriving afterwards has no effect.
- R8: With `USE_FREEZE` = 0, `frz_req` and `frozen` never rise, `core_ce` stays high, and `pin_level` still tracks the pin with two-edge latency.
- R9: The grant-to-freeze transition takes one edge and the release-to-resume transition is bounded by `WAKE_CYCLES` + 3 edges, which sets the worst-case transition time at the design clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_pin_n | input | 1 | Raw asynchronous freeze pin, active low |
| safe_grant | input | 1 | User logic says freezing is safe |
| frz_req | output | 1 | Freeze requested, awaiting grant |
| pin_level | output | 1 | Synchronized pin level |
| core_ce | output | 1 | Clock enable to the protected core |
| in_raw | input | N_IN | Inputs arriving from outside |
| in_core | output | N_IN | Inputs delivered to the core |
| out_core | input | N_OUT | Output values from the core |
| out_oe_core | input | N_OUT | Output enables from the core |
| out_pad | output | N_OUT | Output values to the pads |
| out_oe | output | N_OUT | Output enables to the pads |
| out_pull_en | output | N_OUT | Weak pull enable per output |
| out_pull_up | output | N_OUT | Weak pull direction, 1 = up |
| frozen | output | 1 | Region is frozen or waking |

## Verification
The assertions assume `safe_grant` is only meaningful while `frz_req` is high and that the pin, once moved, is held steady for at least the synchronizer depth before it is read as a decision; the bench always holds each pin level for several cycles and raises the grant only after observing the request. The sweeps over grant delay, withdrawal point and every value of an 8-bit input word stay inside that envelope, and `in_raw` and the core outputs toggle freely while frozen since the block must tolerate that.

// File: rtl/frz_seq.sv
module frz_seq #(
  parameter int N_IN = 8,
  parameter int N_OUT = 4,
  parameter int WAKE_CYCLES = 4,
  parameter bit USE_FREEZE = 1'b1,
  parameter logic [N_OUT-1:0] IDLE_PULL_EN = 4'b0110,
  parameter logic [N_OUT-1:0] IDLE_PULL_UP = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frz_pin_n,
  input  logic             safe_grant,
  output logic             frz_req,
  output logic             pin_level,
  output logic             core_ce,
  input  logic [N_IN-1:0]  in_raw,
  output logic [N_IN-1:0]  in_core,
  input  logic [N_OUT-1:0] out_core,
  input  logic [N_OUT-1:0] out_oe_core,
  output logic [N_OUT-1:0] out_pad,
  output logic [N_OUT-1:0] out_oe,
  output logic [N_OUT-1:0] out_pull_en,
  output logic [N_OUT-1:0] out_pull_up,
  output logic             frozen
);
  localparam int CW = $clog2(WAKE_CYCLES + 1) + 1;

  typedef enum logic [1:0] {ST_RUN, ST_ASK, ST_ICE, ST_WAKE} st_t;

  st_t             st_q, st_d;
  logic [1:0]      sync_q;
  logic [CW-1:0]   cnt_q;
  logic [N_IN-1:0] in_q;
  logic            want, hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], frz_pin_n};

  assign pin_level = sync_q[1];
  assign want = USE_FREEZE && !pin_level;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (want) st_d = ST_ASK;
      ST_ASK:  if (!want) st_d = ST_RUN;
               else if (safe_grant) st_d = ST_ICE;
      ST_ICE:  if (!want) st_d = ST_WAKE;
      ST_WAKE: if (cnt_q == '0) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ICE && st_d == ST_WAKE) cnt_q <= CW'(WAKE_CYCLES - 1);
      else if (st_q == ST_WAKE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

  assign hold    = (st_q == ST_ICE) || (st_q == ST_WAKE);
  assign frz_req = (st_q == ST_ASK);
  assign core_ce = !hold;
  assign frozen  = hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     in_q <= '0;
    else if (!hold) in_q <= in_raw;

  assign in_core     = hold ? in_q : in_raw;
  assign out_pad     = hold ? '0 : out_core;
  assign out_oe      = hold ? '0 : out_oe_core;
  assign out_pull_en = hold ? IDLE_PULL_EN : '0;
  assign out_pull_up = hold ? IDLE_PULL_UP : '0;

  logic [CW:0] exit_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) exit_cnt <= '0;
    else if (frozen && pin_level) exit_cnt <= exit_cnt + 1'b1;
    else exit_cnt <= '0;

  p_enable_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !core_ce);
  p_grant_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_req && safe_grant && !pin_level) |=> frozen);
  p_entry_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(safe_grant) && $past(frz_req));
  p_input_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(in_core));
  p_idle_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (out_oe == '0 && out_pull_en == IDLE_PULL_EN));
  p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_req && pin_level) |=> (!frz_req && !frozen));
  p_exit_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exit_cnt <= (CW+1)'(WAKE_CYCLES + 1));

  generate
    if (!USE_FREEZE) begin : g_off
      p_never_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frz_req && !frozen);
    end
  endgenerate
endmodule

// File: tb/frz_seq_tb_top.sv
module frz_seq_tb_top;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_n = 1'b1, grant = 1'b0;
  logic [7:0] in_raw = 8'h00;
  logic [3:0] oc = 4'h0, ooe = 4'h0;
  logic frz_req, pin_level, core_ce, frozen;
  logic [7:0] in_core;
  logic [3:0] out_pad, out_oe, pen, pup;
  logic nreq, nlvl, nce, nfrz;
  logic [7:0] nin;
  logic [3:0] npad, noe, npen, npup;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frz_seq #(.WAKE_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frz_pin_n(pin_n), .safe_grant(grant),
    .frz_req(frz_req), .pin_level(pin_level), .core_ce(core_ce),
    .in_raw(in_raw), .in_core(in_core), .out_core(oc), .out_oe_core(ooe),
    .out_pad(out_pad), .out_oe(out_oe), .out_pull_en(pen), .out_pull_up(pup),
    .frozen(frozen));

  frz_seq #(.WAKE_CYCLES(W), .USE_FREEZE(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .frz_pin_n(pin_n), .safe_grant(grant),
    .frz_req(nreq), .pin_level(nlvl), .core_ce(nce),
    .in_raw(in_raw), .in_core(nin), .out_core(oc), .out_oe_core(ooe),
    .out_pad(npad), .out_oe(noe), .out_pull_en(npen), .out_pull_up(npup),
    .frozen(nfrz));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enter(input int gdelay);
    pin_n = 1'b0;
    tick(3);
    chk(frz_req == 1'b1, "R1 req third edge", frz_req, 1);
    tick(gdelay);
    chk(frozen == 1'b0 && core_ce == 1'b1, "R2 no freeze before grant", frozen, 0);
    grant = 1'b1;
    tick(1);
    grant = 1'b0;
    chk(frozen == 1'b1, "R2 frozen one edge after grant", frozen, 1);
    chk(core_ce == 1'b0, "R3 enable off", core_ce, 0);
  endtask

  task automatic leave();
    pin_n = 1'b1;
    tick(2 + W);
    chk(frozen == 1'b1 && core_ce == 1'b0, "R6 still waking", core_ce, 0);
    tick(1);
    chk(frozen == 1'b0 && core_ce == 1'b1, "R6 resumed at 3+W", core_ce, 1);
    chk(in_core == in_raw, "R6 inputs live", in_core, in_raw);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(frz_req == 0 && frozen == 0 && core_ce == 1 && pin_level == 1, "R1 reset state", frozen, 0);

    pin_n = 1'b0;
    tick(2);
    chk(pin_level == 1'b0 && frz_req == 1'b0, "R1 sync two edges", pin_level, 0);
    tick(1);
    chk(frz_req == 1'b1, "R1 request third edge", frz_req, 1);
    tick(50);
    chk(frozen == 0 && core_ce == 1 && frz_req == 1, "R2 no grant no freeze", frozen, 0);
    pin_n = 1'b1;
    tick(2);
    chk(frz_req == 1'b1, "R7 req before third edge", frz_req, 1);
    tick(1);
    chk(frz_req == 1'b0 && frozen == 1'b0, "R7 withdrawn", frz_req, 0);
    grant = 1'b1;
    tick(3);
    grant = 1'b0;
    chk(frozen == 1'b0 && core_ce == 1'b1, "R7 late grant ignored", frozen, 0);

    for (int d = 0; d < 6; d++) begin
      in_raw = 8'(8'h3C + d * 17);
      oc = 4'(d); ooe = 4'(~d);
      tick(1);
      chk(in_core == in_raw && out_pad == oc && out_oe == ooe && pen == 0 && pup == 0,
          "R5 active passthrough", {out_pad, out_oe}, {oc, ooe});
      enter(d);
      chk(in_core == 8'(8'h3C + d * 17), "R4 entry value held", in_core, 8'h3C + d * 17);
      in_raw = ~in_raw; oc = ~oc; ooe = 4'hF;
      tick(2);
      chk(in_core == 8'(8'h3C + d * 17), "R4 held under toggling", in_core, 8'h3C + d * 17);
      chk(out_oe == 0 && out_pad == 0 && pen == 4'b0110 && pup == 4'b0100,
          "R5 idle outputs", {pen, pup}, 8'h64);
      leave();
      tick(2);
    end

    for (int w = 0; w < 4; w++) begin
      pin_n = 1'b0;
      tick(3 + w);
      chk(frz_req == 1'b1, "R7 req held", frz_req, 1);
      pin_n = 1'b1;
      tick(3);
      chk(frz_req == 0 && frozen == 0 && core_ce == 1, "R7 withdraw sweep", frz_req, 0);
      tick(2);
    end

    in_raw = 8'hA5;
    tick(1);
    enter(1);
    for (int v = 0; v < 256; v++) begin
      in_raw = 8'(v); oc = 4'(v); ooe = 4'(v >> 4);
      tick(1);
      chk(in_core == 8'hA5 && core_ce == 0 && out_oe == 0 && out_pad == 0,
          "R4 sweep hold", in_core, 8'hA5);
    end
    leave();

    for (int v = 0; v < 256; v++) begin
      in_raw = 8'(v);
      tick(1);
      chk(in_core == 8'(v), "R4 sweep passthrough", in_core, v);
    end

    pin_n = 1'b0; grant = 1'b1;
    tick(2);
    chk(nlvl == 1'b0, "R8 pin level tracks", nlvl, 0);
    tick(6);
    chk(nreq == 0 && nfrz == 0 && nce == 1 && nin == in_raw, "R8 never freezes", nfrz, 0);
    chk(frozen == 1'b1, "R9 fast entry with early grant", frozen, 1);
    grant = 1'b0; pin_n = 1'b1;
    tick(3 + W);
    chk(core_ce == 1'b1 && nlvl == 1'b1, "R9 exit bounded", core_ce, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule